// File: doc/BRIEF.md
# Multi-Mode Acquisition Trigger Controller

This block decides when a three-channel measurement is taken. A 3-bit mode code selects which events may start a conversion. The host acquire command always can. A falling edge on an active-low external read-request line can start one in two of the modes. A rising edge on the selected interrupt line can start one in two other modes. The two external lines are asynchronous and pass through a two-flop synchronizer before their edges are detected.

At every start the block captures the current value of a free-running 16-bit timestamp counter. It then raises `busy` for a fixed number of clock cycles, which model the converter's latency. When `busy` falls it issues a one-cycle completion pulse and publishes the three 16-bit two's-complement axis words. Some modes also drive a sync output for exactly the busy window. The read-request-with-interrupt mode additionally flags the completion as an interrupt request.

The converter is a stub. It samples the three channel inputs at the start and presents them when the conversion ends.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, `mode_q` is 000, and `busy`, `sync_out`, `done`, `done_irq`, `ts_ovf`, `ts_latched` and all axis outputs are 0. The timestamp counter starts from 0.
- R2: A cycle with `mode_wr` high loads `mode_in` into `mode_q`, and the new value governs triggers from the next cycle on. Codes 000 to 101 are modes 0 to 5. Codes 110 and 111 behave exactly like 000: command trigger only, no sync and no interrupt flag.
- R3: `acq_cmd` sampled high on an edge while idle starts an acquisition in every mode, and `busy` is 1 right after that edge.
- R4: In modes 2 (010) and 3 (011), a falling edge on `rd_req_n` starts an acquisition. `busy` rises after the second edge following the first edge that samples the low level. In all other modes that edge has no effect.
- R5: In modes 4 (100) and 5 (101), a rising edge on `irq_line` starts an acquisition with the same latency as R4. A line that stays high never starts a second one; it must return to 0 and rise again.
- R6: `busy` stays high for exactly `CONV_CYC` cycles. Any trigger that arrives while `busy` is high is ignored.
- R7: `done` is a one-cycle pulse in the first cycle after `busy` falls. `done_irq` pulses together with `done` only for acquisitions started in mode 3.
- R8: For acquisitions started in modes 1 (001) and 5 (101), `sync_out` equals `busy` for the whole acquisition. Otherwise `sync_out` stays 0.
- R9: At each start, `ts_latched` takes the counter value present before that edge. The counter advances by 1 every cycle, and `ts_latched` changes at no other time.
- R10: The counter wraps from 0xFFFF to 0 and sets the sticky `ts_ovf` flag. A cycle with `ts_clr` high zeroes both the counter and `ts_ovf`.
- R11: The axis outputs take the channel inputs sampled at the start edge, on the edge where `busy` falls, and change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load `mode_in` into the mode register |
| mode_in | input | 3 | New mode code |
| acq_cmd | input | 1 | Host acquire command |
| ts_clr | input | 1 | Clear timestamp counter and overflow flag |
| rd_req_n | input | 1 | Asynchronous external read request, active low |
| irq_line | input | 1 | Asynchronous selected interrupt line, active high |
| ch_x_in | input | AXIS_W | X channel converter input |
| ch_y_in | input | AXIS_W | Y channel converter input |
| ch_z_in | input | AXIS_W | Z channel converter input |
| mode_q | output | 3 | Stored mode code |
| busy | output | 1 | Conversion in progress |
| sync_out | output | 1 | Sync strobe during busy in sync modes |
| done | output | 1 | One-cycle completion pulse |
| done_irq | output | 1 | Completion flagged as interrupt (mode 3) |
| ts_latched | output | TS_W | Timestamp captured at the last start |
| ts_ovf | output | 1 | Sticky counter wrap flag |
| x_out | output | AXIS_W | X axis result |
| y_out | output | AXIS_W | Y axis result |
| z_out | output | AXIS_W | Z axis result |

## Verification
A host command is seen one edge after it is sampled: `busy`, `sync_out` and `ts_latched` all change on that same edge. An external line edge needs three edges: two synchronizer stages and the start edge. `done`, `done_irq` and the axis words follow `CONV_CYC` edges after the start.

The bench's reference model ages the external inputs through a short history queue. It counts the busy window down, and it is compared with every output at each falling clock edge. No result is therefore read before the edge that produces it. Directed checks also sample `busy` and `done` at the exact expected edges after each kind of trigger, including ignored triggers and a held-high interrupt line.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  typedef enum logic [2:0] {
    MD_CMD       = 3'd0,
    MD_CMD_SYNC  = 3'd1,
    MD_RD        = 3'd2,
    MD_RD_IRQ    = 3'd3,
    MD_LINE      = 3'd4,
    MD_LINE_SYNC = 3'd5
  } acq_mode_e;

  // Codes above the last defined mode fall back to command-only.
  function automatic acq_mode_e eff_mode(input logic [2:0] code);
    if (code > 3'd5) return MD_CMD;
    return acq_mode_e'(code);
  endfunction

  function automatic logic mode_has_sync(input acq_mode_e m);
    return (m == MD_CMD_SYNC) || (m == MD_LINE_SYNC);
  endfunction

  function automatic logic mode_uses_rd(input acq_mode_e m);
    return (m == MD_RD) || (m == MD_RD_IRQ);
  endfunction

  function automatic logic mode_uses_line(input acq_mode_e m);
    return (m == MD_LINE) || (m == MD_LINE_SYNC);
  endfunction

endpackage

// File: rtl/acq_in_sync.sv
module acq_in_sync #(
  parameter bit IDLE = 1'b0,
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic edge_hit
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= IDLE;
      s2   <= IDLE;
      prev <= IDLE;
    end else begin
      s1   <= raw_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign edge_hit = s2 & ~prev;
    end else begin : g_fall
      assign edge_hit = prev & ~s2;
    end
  endgenerate
endmodule

// File: rtl/acq_timestamp.sv
module acq_timestamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            latch,
  output logic [TS_W-1:0] ts_latched,
  output logic            ts_ovf
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic [TS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      ts_ovf <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      ts_ovf <= 1'b0;
    end else if (cnt == TS_MAX) begin
      cnt    <= '0;
      ts_ovf <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ts_latched <= '0;
    else if (latch) ts_latched <= cnt;
  end
endmodule

// File: rtl/acq_conv_stub.sv
module acq_conv_stub #(
  parameter int CONV_CYC = 3750,
  parameter int AXIS_W   = 16,
  parameter int NUM_CH   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [NUM_CH-1:0][AXIS_W-1:0] ch_in,
  output logic                          active,
  output logic                          fin,
  output logic                          done,
  output logic [NUM_CH-1:0][AXIS_W-1:0] ch_out
);
  localparam int CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYC - 1);

  logic [CW-1:0] rem;

  assign fin = active && (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      rem    <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (start) begin
        active <= 1'b1;
        rem    <= LOAD;
      end else if (fin) begin
        active <= 1'b0;
      end else if (active) begin
        rem <= rem - 1'b1;
      end
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [AXIS_W-1:0] hold;
      always_ff @(posedge clk) begin
        if (rst) begin
          hold      <= '0;
          ch_out[c] <= '0;
        end else begin
          if (start) hold <= ch_in[c];
          if (fin)   ch_out[c] <= hold;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CONV_CYC = 3750,
  parameter int AXIS_W   = 16,
  parameter int TS_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [2:0]        mode_in,
  input  logic              acq_cmd,
  input  logic              ts_clr,
  input  logic              rd_req_n,
  input  logic              irq_line,
  input  logic [AXIS_W-1:0] ch_x_in,
  input  logic [AXIS_W-1:0] ch_y_in,
  input  logic [AXIS_W-1:0] ch_z_in,
  output logic [2:0]        mode_q,
  output logic              busy,
  output logic              sync_out,
  output logic              done,
  output logic              done_irq,
  output logic [TS_W-1:0]   ts_latched,
  output logic              ts_ovf,
  output logic [AXIS_W-1:0] x_out,
  output logic [AXIS_W-1:0] y_out,
  output logic [AXIS_W-1:0] z_out
);
  localparam int NUM_CH  = 3;
  localparam int NUM_EXT = 2;   // index 0: read request (falling), 1: line (rising)

  logic [NUM_EXT-1:0] ext_raw, ext_hit;
  assign ext_raw = {irq_line, rd_req_n};

  genvar i;
  generate
    for (i = 0; i < NUM_EXT; i++) begin : g_ext
      acq_in_sync #(
        .IDLE(i == 0),
        .RISE(i == 1)
      ) u_sync (
        .clk(clk), .rst(rst), .raw_in(ext_raw[i]), .edge_hit(ext_hit[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 3'd0;
    else if (mode_wr) mode_q <= mode_in;
  end

  acq_mode_e cur_mode;
  logic      start, fin, acq_irq;

  assign cur_mode = eff_mode(mode_q);
  assign start = !busy && (acq_cmd
                 || (mode_uses_rd(cur_mode)   && ext_hit[0])
                 || (mode_uses_line(cur_mode) && ext_hit[1]));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_out <= 1'b0;
      acq_irq  <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= fin && acq_irq;
      if (start) begin
        sync_out <= mode_has_sync(cur_mode);
        acq_irq  <= (cur_mode == MD_RD_IRQ);
      end else if (fin) begin
        sync_out <= 1'b0;
      end
    end
  end

  acq_timestamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst(rst), .clr(ts_clr), .latch(start),
    .ts_latched(ts_latched), .ts_ovf(ts_ovf)
  );

  logic [NUM_CH-1:0][AXIS_W-1:0] ch_in_p, ch_out_p;
  assign ch_in_p = {ch_z_in, ch_y_in, ch_x_in};

  acq_conv_stub #(.CONV_CYC(CONV_CYC), .AXIS_W(AXIS_W), .NUM_CH(NUM_CH)) u_conv (
    .clk(clk), .rst(rst), .start(start), .ch_in(ch_in_p),
    .active(busy), .fin(fin), .done(done), .ch_out(ch_out_p)
  );

  assign x_out = ch_out_p[0];
  assign y_out = ch_out_p[1];
  assign z_out = ch_out_p[2];
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
module acq_trig_ctrl_chk #(
  parameter int CONV_CYC = 3750,
  parameter int AXIS_W   = 16,
  parameter int TS_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              sync_out,
  input logic              done,
  input logic              done_irq,
  input logic [TS_W-1:0]   ts_latched,
  input logic [AXIS_W-1:0] x_out,
  input logic [AXIS_W-1:0] y_out,
  input logic [AXIS_W-1:0] z_out
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  p_busy_max_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < CONV_CYC));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(busy_run) == CONV_CYC - 1));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_irq_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> done);

  p_sync_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> busy);

  p_ts_only_at_start_r9: assert property (@(posedge clk) disable iff (rst)
    !$rose(busy) |-> $stable(ts_latched));

  p_axes_only_at_end_r11: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> ($stable(x_out) && $stable(y_out) && $stable(z_out)));
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(
  .CONV_CYC(CONV_CYC), .AXIS_W(AXIS_W), .TS_W(TS_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sync_out(sync_out), .done(done),
  .done_irq(done_irq), .ts_latched(ts_latched),
  .x_out(x_out), .y_out(y_out), .z_out(z_out)
);

// File: tb/acq_trig_ctrl_test.sv
`timescale 1ns/1ps
module acq_trig_ctrl_test;
  localparam int C  = 12;
  localparam int AW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 1'b0;
  logic [2:0] mode_in = 3'd0;
  logic acq_cmd = 1'b0, ts_clr = 1'b0, rd_req_n = 1'b1, irq_line = 1'b0;
  logic [AW-1:0] ch_x_in = '0, ch_y_in = '0, ch_z_in = '0;
  logic [2:0] mode_q;
  logic busy, sync_out, done, done_irq, ts_ovf;
  logic [TW-1:0] ts_latched;
  logic [AW-1:0] x_out, y_out, z_out;

  always #2 clk = ~clk;

  acq_trig_ctrl #(.CONV_CYC(C), .AXIS_W(AW), .TS_W(TW)) uut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
    .acq_cmd(acq_cmd), .ts_clr(ts_clr), .rd_req_n(rd_req_n), .irq_line(irq_line),
    .ch_x_in(ch_x_in), .ch_y_in(ch_y_in), .ch_z_in(ch_z_in),
    .mode_q(mode_q), .busy(busy), .sync_out(sync_out), .done(done),
    .done_irq(done_irq), .ts_latched(ts_latched), .ts_ovf(ts_ovf),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // ---------------- reference model ----------------
  int m_mode, m_left, m_cnt;
  bit m_busy, m_done, m_dirq, m_sync, m_irqacq, m_ovf;
  longint m_ts, m_x, m_y, m_z, h_x, h_y, h_z;
  int rdq[$], lnq[$];

  function automatic int eff(input int code);
    return (code > 5) ? 0 : code;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_left = 0; m_cnt = 0; m_busy = 0; m_done = 0; m_dirq = 0;
      m_sync = 0; m_irqacq = 0; m_ovf = 0; m_ts = 0;
      m_x = 0; m_y = 0; m_z = 0; h_x = 0; h_y = 0; h_z = 0;
      rdq = '{1, 1, 1};
      lnq = '{0, 0, 0};
    end else begin
      automatic int e = eff(m_mode);
      automatic bit rd_fall = (rdq[2] == 1) && (rdq[1] == 0);
      automatic bit ln_rise = (lnq[2] == 0) && (lnq[1] == 1);
      automatic bit go = !m_busy && (acq_cmd
                         || ((e == 2 || e == 3) && rd_fall)
                         || ((e == 4 || e == 5) && ln_rise));
      m_done = 0;
      m_dirq = 0;
      if (go) begin
        m_busy = 1; m_left = C; m_ts = m_cnt;
        m_sync = (e == 1 || e == 5);
        m_irqacq = (e == 3);
        h_x = ch_x_in; h_y = ch_y_in; h_z = ch_z_in;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_sync = 0; m_done = 1; m_dirq = m_irqacq;
          m_x = h_x; m_y = h_y; m_z = h_z;
        end
      end
      if (ts_clr) begin m_cnt = 0; m_ovf = 0; end
      else if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; end
      else m_cnt++;
      if (mode_wr) m_mode = int'(mode_in);
      rdq.push_front(int'(rd_req_n)); void'(rdq.pop_back());
      lnq.push_front(int'(irq_line)); void'(lnq.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2",  "mode_q",     mode_q,     m_mode);
      check("R6",  "busy",       busy,       m_busy);
      check("R8",  "sync_out",   sync_out,   m_sync);
      check("R7",  "done",       done,       m_done);
      check("R7",  "done_irq",   done_irq,   m_dirq);
      check("R9",  "ts_latched", ts_latched, m_ts);
      check("R10", "ts_ovf",     ts_ovf,     m_ovf);
      check("R11", "x_out",      x_out,      m_x);
      check("R11", "y_out",      y_out,      m_y);
      check("R11", "z_out",      z_out,      m_z);
    end
    ch_x_in = AW'(cyc * 37 + 5);
    ch_y_in = AW'(16'h8000 + cyc * 11);
    ch_z_in = AW'(16'hFFF0 - cyc * 3);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1; mode_in = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic pulse_cmd();
    @(negedge clk); acq_cmd = 1;
    @(negedge clk); acq_cmd = 0;
  endtask

  initial begin
    tick(4);
    rst = 0;
    // R1 reset state (sampled right after the reset edge)
    check("R1", "busy", busy, 0);
    check("R1", "mode_q", mode_q, 0);
    check("R1", "ts_ovf", ts_ovf, 0);
    check("R1", "x_out", x_out, 0);
    check("R1", "ts_latched", ts_latched, 0);

    // R3 mode 0 host command, R7 done timing, R6 command during busy ignored
    pulse_cmd();
    check("R3", "busy after cmd", busy, 1);
    tick(1);
    acq_cmd = 1; tick(1); acq_cmd = 0;
    tick(C - 3);
    check("R6", "busy last cycle", busy, 1);
    tick(1);
    check("R6", "busy fell", busy, 0);
    check("R7", "done pulse", done, 1);
    check("R7", "no irq in mode0", done_irq, 0);
    tick(3);

    // R4 ignored in mode 0
    @(negedge clk); rd_req_n = 0;
    tick(6);
    check("R4", "rd edge ignored in mode0", busy, 0);
    rd_req_n = 1; tick(4);

    // R4 mode 2 read-request trigger
    set_mode(3'b010);
    @(negedge clk); rd_req_n = 0;
    tick(2);
    check("R4", "busy before sync delay", busy, 0);
    tick(1);
    check("R4", "busy from rd edge", busy, 1);
    rd_req_n = 1; tick(C + 4);

    // R7 mode 3 interrupt flag
    set_mode(3'b011);
    @(negedge clk); rd_req_n = 0;
    tick(3);
    check("R4", "busy from rd edge mode3", busy, 1);
    tick(C);
    check("R7", "done mode3", done, 1);
    check("R7", "done_irq mode3", done_irq, 1);
    rd_req_n = 1; tick(4);

    // R8 mode 1 sync
    set_mode(3'b001);
    pulse_cmd();
    check("R8", "sync mode1", sync_out, 1);
    tick(C);
    check("R8", "sync cleared", sync_out, 0);

    // R5 mode 4 line trigger, held-high line does not re-fire
    set_mode(3'b100);
    @(negedge clk); irq_line = 1;
    tick(3);
    check("R5", "busy from line edge", busy, 1);
    check("R8", "no sync mode4", sync_out, 0);
    tick(3 * C);
    check("R5", "held line no refire", busy, 0);
    irq_line = 0; tick(4);
    @(negedge clk); irq_line = 1;
    tick(3);
    check("R5", "rearmed line fires", busy, 1);
    tick(C + 2);
    irq_line = 0; tick(4);

    // R5/R8 mode 5 line trigger with sync
    set_mode(3'b101);
    @(negedge clk); irq_line = 1;
    tick(3);
    check("R8", "sync mode5", sync_out, 1);
    tick(C + 2);
    irq_line = 0; tick(4);

    // R2 code 110 behaves as mode 0
    set_mode(3'b110);
    @(negedge clk); irq_line = 1; rd_req_n = 0;
    tick(6);
    check("R2", "code6 ignores ext", busy, 0);
    irq_line = 0; rd_req_n = 1; tick(4);
    pulse_cmd();
    check("R2", "code6 cmd works", busy, 1);
    check("R2", "code6 no sync", sync_out, 0);
    tick(C + 2);

    // R10 overflow and clear
    @(negedge clk); ts_clr = 1;
    @(negedge clk); ts_clr = 0;
    tick(65537);
    check("R10", "overflow set", ts_ovf, 1);
    pulse_cmd();
    check("R9", "latched after wrap", ts_latched, m_ts);
    tick(C + 2);
    @(negedge clk); ts_clr = 1;
    @(negedge clk); ts_clr = 0;
    check("R10", "overflow cleared", ts_ovf, 0);
    tick(4);

    finished = 1;
    report();
  end
endmodule